// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier on a Strobed Shared Bus

This block multiplies two IEEE 754 single-precision numbers and returns a single-precision product. It has no clock. Two active-low strobes on a shared 32-bit bus control it. On the rising edge of the load strobe it captures the two operands from their input buses. After that edge the environment may float those buses or reuse them for other traffic. The product is formed combinationally from the captured operands. It is placed on the result bus only while the output strobe is low. At all other times the block leaves the result bus undriven, so other agents can use it.

All operand classes are supported: quiet and signalling NaNs, signed infinities, signed zeros, normal values and subnormal values. Results are rounded to nearest with ties to even. The rounding covers results that fall into the subnormal range and results that round up from the largest subnormal to the smallest normal value. Every NaN result has the canonical pattern 0x7FC00000.

Top module: `fpmul_bus`

## Requirements
- R1: Operands and result use bit 31 as the sign, bits 30:23 as an exponent biased by 127, and bits 22:0 as the fraction. For two normal operands whose product is in range, the result is the exact product rounded to nearest with ties to even.
- R2: The operands are taken from `a_bus` and `b_bus` on the rising edge of `load_n`. Values on those buses at any other time do not change the result.
- R3: `c_bus` is driven only while `drive_n` is low. At all other times every bit of it is released to high impedance.
- R4: The result sign is the XOR of the operand signs for every non-NaN result, including zeros and infinities.
- R5: An operand with exponent 255 and a nonzero fraction is a NaN. If either operand is a NaN, the result is 0x7FC00000, whatever the other operand is.
- R6: Infinity times zero, in either order and with any signs, gives 0x7FC00000.
- R7: Infinity (exponent 255, fraction 0) times any nonzero non-NaN value gives an infinity of the XOR sign.
- R8: A product whose rounded magnitude exceeds the largest finite value gives an infinity of the XOR sign.
- R9: An operand with exponent 0 and a nonzero fraction is treated as 0.f × 2^-126.
- R10: A product below the normal range is returned as a subnormal. Bits shifted out below the fraction feed the rounding, which is to nearest with ties to even.
- R11: A product that rounds up past the largest subnormal (0x007FFFFF) gives the smallest normal value (0x00800000).
- R12: A product of magnitude at most half the smallest subnormal gives a signed zero. A product just above that half gives the smallest subnormal.
- R13: Reset clears both operand registers, so an output cycle with no load before it returns +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the operand registers |
| load_n | input | 1 | Active-low load strobe; operands are captured on its rising edge |
| drive_n | input | 1 | Active-low output enable for `c_bus` |
| a_bus | input | 32 | Operand A bus |
| b_bus | input | 32 | Operand B bus |
| c_bus | output | 32 | Product bus; high impedance while `drive_n` is high |

## Verification
The product depends only on the operand registers. It is therefore valid as soon as `load_n` rises, and `drive_n` gates it onto `c_bus` with no delay. The bench changes strobes and buses on clock rising edges and samples `c_bus` on every falling edge. `drive_n` falls two clocks after the load edge and stays low for three clocks, and every one of those samples must equal the model's product. During the idle cycles between output windows the bench pulls the bus to a fixed pattern, which shows whether the block has released it. Between the load edge and the output window the bench puts unrelated values on the operand buses, so a design that captures at the wrong time returns a wrong product.

// File: rtl/fpmul_bus.sv
module fpmul_bus (
  input  logic        rst_n,
  input  logic        load_n,
  input  logic        drive_n,
  input  logic [31:0] a_bus,
  input  logic [31:0] b_bus,
  output logic [31:0] c_bus
);
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic [31:0] op_a, op_b, result;

  always_ff @(posedge load_n or negedge rst_n)
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
    end else begin
      op_a <= a_bus;
      op_b <= b_bus;
    end

  wire [7:0]  ea = op_a[30:23];
  wire [7:0]  eb = op_b[30:23];
  wire [22:0] fa = op_a[22:0];
  wire [22:0] fb = op_b[22:0];

  wire nan_a  = (&ea) & (|fa);
  wire nan_b  = (&eb) & (|fb);
  wire inf_a  = (&ea) & ~(|fa);
  wire inf_b  = (&eb) & ~(|fb);
  wire zero_a = ~(|ea) & ~(|fa);
  wire zero_b = ~(|eb) & ~(|fb);
  wire sgn    = op_a[31] ^ op_b[31];

  wire [7:0]  ea_eff = (|ea) ? ea : 8'd1;
  wire [7:0]  eb_eff = (|eb) ? eb : 8'd1;
  wire [47:0] prod   = {24'b0, |ea, fa} * {24'b0, |eb, fb};

  logic [5:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < 48; i++)
      if (prod[i]) lz = 6'(47 - i);
  end

  wire [47:0] norm = prod << lz;

  logic signed [10:0] exp_s;
  assign exp_s = $signed({3'b000, ea_eff}) + $signed({3'b000, eb_eff})
               - 11'sd126 - $signed({5'b00000, lz});

  wire        tiny    = exp_s < 11'sd1;
  wire        huge    = exp_s > 11'sd254;
  wire [10:0] sh_full = 11'(11'sd1 - exp_s);
  wire [5:0]  sh      = !tiny ? 6'd0 : (sh_full > 11'd48) ? 6'd48 : sh_full[5:0];

  wire [47:0] shifted = norm >> sh;
  wire        lost    = |(norm & ~({48{1'b1}} << sh));
  wire [23:0] mant    = shifted[47:24];
  wire        guard   = shifted[23];
  wire        sticky  = (|shifted[22:0]) | lost;
  wire        inc     = guard & (sticky | mant[0]);

  wire [7:0]  ebase = tiny ? 8'd0 : 8'(exp_s[7:0] - 8'd1);
  wire [30:0] mag   = {ebase, 23'b0} + {7'b0, mant} + {30'b0, inc};

  always_comb begin
    if (nan_a || nan_b)                          result = QNAN;
    else if ((inf_a && zero_b) || (inf_b && zero_a)) result = QNAN;
    else if (inf_a || inf_b || huge)             result = {sgn, 8'hFF, 23'b0};
    else if (zero_a || zero_b)                   result = {sgn, 31'b0};
    else                                         result = {sgn, mag};
  end

  assign c_bus = drive_n ? 32'bz : result;
endmodule

// File: rtl/fpmul_bus_chk.sv
module fpmul_bus_chk (
  input logic        rst_n,
  input logic        load_n,
  input logic        drive_n,
  input logic [31:0] a_bus,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [31:0] result
);
  wire a_nan  = (&op_a[30:23]) & (|op_a[22:0]);
  wire b_nan  = (&op_b[30:23]) & (|op_b[22:0]);
  wire a_inf  = (&op_a[30:23]) & ~(|op_a[22:0]);
  wire b_inf  = (&op_b[30:23]) & ~(|op_b[22:0]);
  wire a_zero = ~(|op_a[30:0]);
  wire b_zero = ~(|op_b[30:0]);
  wire r_nan  = (&result[30:23]) & (|result[22:0]);

  a_r2_capture_edge: assert property (@(posedge load_n) disable iff (!rst_n)
    rst_n |=> (op_a == $past(a_bus)));

  a_r5_nan_out: assert property (@(negedge drive_n) disable iff (!rst_n)
    (a_nan || b_nan) |-> (result == 32'h7FC0_0000));

  a_r6_inf_zero: assert property (@(negedge drive_n) disable iff (!rst_n)
    ((a_inf && b_zero) || (b_inf && a_zero)) |-> (result == 32'h7FC0_0000));

  a_r4_sign_xor: assert property (@(negedge drive_n) disable iff (!rst_n)
    !r_nan |-> (result[31] == (op_a[31] ^ op_b[31])));

  a_r7_inf_out: assert property (@(negedge drive_n) disable iff (!rst_n)
    ((a_inf && !b_zero && !b_nan) || (b_inf && !a_zero && !a_nan)) |-> (result[30:0] == 31'h7F80_0000));
endmodule

bind fpmul_bus fpmul_bus_chk u_chk (
  .rst_n(rst_n), .load_n(load_n), .drive_n(drive_n), .a_bus(a_bus),
  .op_a(op_a), .op_b(op_b), .result(result)
);

// File: tb/tb_fpmul_bus.sv
module tb_fpmul_bus;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PULL = 32'hA5C3_5A3C;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 0, load_n = 1, drive_n = 1;
  logic [31:0] a_drv = '0, b_drv = '0, exp_val = '0;
  wire  [31:0] c_bus;
  string cur_req = "R13";
  int checks = 0, fails = 0;
  bit mon_on = 0, done = 0;

  fpmul_bus dut (.rst_n(rst_n), .load_n(load_n), .drive_n(drive_n),
                 .a_bus(a_drv), .b_bus(b_drv), .c_bus(c_bus));

  assign c_bus = drive_n ? PULL : 32'bz;

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic s = a[31] ^ b[31];
    int ea = int'(a[30:23]), eb = int'(b[30:23]);
    bit na = (ea == 255) && (a[22:0] != 0), nb = (eb == 255) && (b[22:0] != 0);
    bit ia = (ea == 255) && (a[22:0] == 0), ib = (eb == 255) && (b[22:0] == 0);
    bit za = (ea == 0) && (a[22:0] == 0),   zb = (eb == 0) && (b[22:0] == 0);
    longint unsigned p, ma, mb;
    int x;
    bit g = 0, st = 0;
    if (na || nb) return 32'h7FC0_0000;
    if ((ia && zb) || (ib && za)) return 32'h7FC0_0000;
    if (ia || ib) return {s, 8'hFF, 23'h0};
    if (za || zb) return {s, 31'h0};
    ma = longint'(a[22:0]) + ((ea != 0) ? 64'd8388608 : 64'd0);
    mb = longint'(b[22:0]) + ((eb != 0) ? 64'd8388608 : 64'd0);
    x = ((ea == 0) ? 1 : ea) - 150 + ((eb == 0) ? 1 : eb) - 150;
    p = ma * mb;
    while (p < 64'd8388608 && x > -149) begin p = p << 1; x = x - 1; end
    while (p >= 64'd16777216 || x < -149) begin
      st = st | g; g = p[0]; p = p >> 1; x = x + 1;
    end
    if (g && (st || p[0])) p = p + 1;
    if (p == 64'd16777216) begin p = p >> 1; x = x + 1; end
    if (p < 64'd8388608) return {s, 8'h00, p[22:0]};
    if (x + 150 >= 255) return {s, 8'hFF, 23'h0};
    return {s, 8'(x + 150), p[22:0]};
  endfunction

  always @(negedge clk) if (mon_on) begin
    checks++;
    if (!drive_n) begin
      if (c_bus !== exp_val) begin
        fails++;
        $display("FAIL %s: c_bus=%h expected %h", cur_req, c_bus, exp_val);
      end
    end else if (c_bus !== PULL) begin
      fails++;
      $display("FAIL R3: released bus reads %h expected %h", c_bus, PULL);
    end
  end

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string req);
    @(posedge clk); a_drv = a; b_drv = b; load_n = 0;
    @(posedge clk); load_n = 1; exp_val = ref_mul(a, b); cur_req = req;
    @(posedge clk); a_drv = ~a; b_drv = b ^ 32'h3F80_1234;
    @(posedge clk); drive_n = 0;
    repeat (3) @(posedge clk);
    drive_n = 1;
    @(posedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1;
    mon_on = 1;
    @(posedge clk);
    exp_val = 32'h0; cur_req = "R13 reset operands";
    drive_n = 0;
    repeat (2) @(posedge clk);
    drive_n = 1;
    @(posedge clk);

    run(32'h41C8_0000, 32'hC1C8_0000, "R1 25*-25");
    run(32'h41C8_0000, 32'h3C23_D70A, "R1 25*0.01");
    run(32'h3FC0_0000, 32'h3F80_0001, "R1 guard-only round");
    run(32'h3FAA_AAAB, 32'h3FAA_AAAB, "R1 guard+sticky round");
    run(32'h4049_0FDB, 32'hC02D_F854, "R1 mixed sign");
    run(32'h41C8_0000, 32'h0000_0000, "R2 capture then bus change");
    run(32'h41C8_0000, 32'h8000_0000, "R4 25*-0");
    run(32'hC1C8_0000, 32'hFF80_0000, "R4 -25*-inf");
    run(32'h7F80_0001, 32'h3F80_0000, "R5 nan*1");
    run(32'h7FC0_0000, 32'h7F80_0000, "R5 nan*inf");
    run(32'h8000_0000, 32'hFFFF_FFFF, "R5 -0*nan");
    run(32'h0000_0001, 32'h7FA0_0000, "R5 denorm*nan");
    run(32'h7F80_0000, 32'h8000_0000, "R6 inf*-0");
    run(32'h0000_0000, 32'hFF80_0000, "R6 0*-inf");
    run(32'hFF80_0000, 32'h41C8_0000, "R7 -inf*25");
    run(32'h7F80_0000, 32'h0000_0005, "R7 inf*denorm");
    run(32'h7F7F_FFFF, 32'h4000_0000, "R8 max*2");
    run(32'hFF7F_FFFF, 32'h3F80_0001, "R8 -max rounds over");
    run(32'h0000_0001, 32'h7180_0000, "R9 denorm*2^100");
    run(32'h0040_0000, 32'h4B00_0000, "R9 denorm*2^23");
    run(32'h0D80_0000, 32'h3080_0000, "R10 2^-130");
    run(32'h0000_0003, 32'h3F00_0000, "R10 tie to even up");
    run(32'h0000_0005, 32'h3F00_0000, "R10 tie to even down");
    run(32'h007F_FFFF, 32'h3F80_0000, "R11 max denorm exact");
    run(32'h007F_FFFF, 32'h3F80_0001, "R11 round to min normal");
    run(32'h0000_0001, 32'h3F00_0000, "R12 exact half flushes");
    run(32'h8000_0001, 32'h3F00_0001, "R12 above half");
    run(32'h0000_0001, 32'h3E80_0000, "R12 quarter flushes");
    run(32'h0000_0001, 32'h0000_0001, "R12 denorm*denorm");

    mon_on = 0;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule